// File: doc/BRIEF.md
# Square-Wave Tone Channel with Rate Shift Control

This block produces a 4-bit square-wave level for one sound voice. A programmable 12-bit period sets how many clock-enable pulses pass between waveform steps, and a 16-step sequencer turns the step position into a low or high level. The duty value sets how many of the last steps in each cycle are high. The high level equals the programmed volume.

A separate rate-control byte acts on the whole divider. One bit freezes it. The other two bits reload the divider from the period shifted right by four or by eight. The stored period is never changed by these bits, so clearing them restores the original pitch.

Software reaches the block through a byte write port with a two-bit select. Clearing the enable bit silences the voice and rewinds its waveform to the first step.

Top module: `pulse_chan`

## Requirements
- R1: The write port has four targets, chosen by `wr_sel`. Select 0 writes the tone byte: bit 7 is the flat flag, bits 6:4 are the duty and bits 3:0 are the volume. Select 1 writes period bits 7:0. Select 2 writes period bits 11:8 from data bits 3:0 and the enable flag from data bit 7. Select 3 writes the rate byte.
- R2: While enabled and not frozen, the step index goes up by one (wrapping 15 to 0) once every P+1 cycles with `tick` high. P is the effective period. The first step happens P+1 ticks after enabling. With `tick` low, nothing advances.
- R3: Rate bit 0 set freezes the divider and the step index. The level holds its value, high or low, until the bit is cleared. Then stepping resumes.
- R4: With only rate bit 1 set (bits 0 and 2 clear), the effective period is the stored period shifted right by 4. For example, 0x123 behaves as 0x12.
- R5: Rate bit 2 set, bit 0 clear, gives an effective period equal to the stored period shifted right by 8, whatever bit 1 is. For example, 0x2AB behaves as 0x2.
- R6: Rate bit 0 wins over bits 1 and 2. Rate bits 7:3 have no effect.
- R7: The rate bits never modify the stored period. After a shifted run, clearing the rate byte gives the full-period pitch again without rewriting the period.
- R8: While enable is 0, the level is 0 and the step index is held at 0. Re-enabling starts a fresh cycle at step 0.
- R9: With the flat flag clear, the level equals the volume when step >= 15 - duty and is 0 otherwise. Each cycle therefore starts low and ends with duty+1 high steps.
- R10: With the flat flag set and the channel enabled, the level is the volume at every step.
- R11: After synchronous reset, the enable flag, the rate byte, the period and the tone byte are 0, and the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable that paces the divider |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 8 | Write data byte |
| level | output | 4 | Channel output level |

## Verification
The bench builds the channel with its default parameters: a 12-bit period, shifts of 4 and 8, and a 16-step sequence with a 4-bit volume. Periods of 0 to 3 complete whole 16-step cycles within a few dozen cycles, so the duty edges and the wrap from step 15 to step 0 can be checked exactly. A 12-bit period of 0x2AB collapses to 2 under the eight-bit shift, which lets the coarse mode and its precedence over the fine mode be checked in under a hundred cycles. The full-width periods 0xF7 and 0x123 fit within a few thousand cycles, so the unshifted pitch and its restoration can be checked as well.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

    localparam int PER_W  = 12;
    localparam int STEP_W = 4;
    localparam int VOL_W  = 4;
    localparam int DUTY_W = 3;

    typedef enum logic [1:0] {
        SEL_TONE = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_RATE = 2'd3
    } sel_e;

    // tone byte: flat flag, duty, volume
    typedef struct packed {
        logic              flat;
        logic [DUTY_W-1:0] duty;
        logic [VOL_W-1:0]  vol;
    } tone_t;

    // rate control: bit2 coarse shift, bit1 fine shift, bit0 freeze
    typedef struct packed {
        logic coarse;
        logic fine;
        logic freeze;
    } rate_t;

endpackage

// File: rtl/pulse_regs.sv
module pulse_regs
    import pulse_pkg::*;
#(
    parameter int P_W = PER_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [7:0]     wr_data,
    output tone_t          tone,
    output logic [P_W-1:0] period,
    output logic           en,
    output rate_t          rate
);
    localparam int HI_W = P_W - 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            tone   <= '0;
            period <= '0;
            en     <= 1'b0;
            rate   <= '0;
        end else if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_TONE: tone <= tone_t'(wr_data);
                SEL_PLO:  period[7:0] <= wr_data;
                SEL_PHI: begin
                    period[P_W-1:8] <= wr_data[HI_W-1:0];
                    en              <= wr_data[7];
                end
                SEL_RATE: rate <= rate_t'(wr_data[2:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pulse_divider.sv
module pulse_divider
    import pulse_pkg::*;
#(
    parameter int P_W       = PER_W,
    parameter int SH_FINE   = 4,
    parameter int SH_COARSE = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           en,
    input  rate_t          rate,
    input  logic [P_W-1:0] period,
    output logic [P_W-1:0] cnt,
    output logic           step_pulse
);
    logic [P_W-1:0] fine_val;
    logic [P_W-1:0] coarse_val;
    logic [P_W-1:0] reload;

    generate
        if (SH_FINE >= P_W) begin : g_fine_zero
            assign fine_val = '0;
        end else begin : g_fine_shift
            assign fine_val = period >> SH_FINE;
        end
        if (SH_COARSE >= P_W) begin : g_coarse_zero
            assign coarse_val = '0;
        end else begin : g_coarse_shift
            assign coarse_val = period >> SH_COARSE;
        end
    endgenerate

    always_comb begin
        if (rate.coarse)    reload = coarse_val;
        else if (rate.fine) reload = fine_val;
        else                reload = period;
    end

    assign step_pulse = en && tick && !rate.freeze && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= reload;
        end else if (tick && !rate.freeze) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
    import pulse_pkg::*;
#(
    parameter int S_W = STEP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step_pulse,
    input  tone_t            tone,
    output logic [S_W-1:0]   step,
    output logic [VOL_W-1:0] level
);
    localparam logic [S_W-1:0] LAST = '1;

    logic [S_W-1:0] thr;

    assign thr = LAST - S_W'(tone.duty);

    always_ff @(posedge clk) begin
        if (rst || !en)     step <= '0;
        else if (step_pulse) step <= step + 1'b1;
    end

    always_comb begin
        if (!en)              level = '0;
        else if (tone.flat)   level = tone.vol;
        else if (step >= thr) level = tone.vol;
        else                  level = '0;
    end
endmodule

// File: rtl/pulse_chan.sv
module pulse_chan
    import pulse_pkg::*;
#(
    parameter int P_W       = PER_W,
    parameter int S_W       = STEP_W,
    parameter int SH_FINE   = 4,
    parameter int SH_COARSE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [3:0] level
);
    tone_t          tone_q;
    rate_t          rate_q;
    logic [P_W-1:0] period_q;
    logic           en_q;
    logic [P_W-1:0] cnt_q;
    logic           step_pulse;
    logic [S_W-1:0] step_q;

    pulse_regs #(.P_W(P_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tone(tone_q), .period(period_q),
        .en(en_q), .rate(rate_q)
    );

    pulse_divider #(.P_W(P_W), .SH_FINE(SH_FINE), .SH_COARSE(SH_COARSE)) u_div (
        .clk(clk), .rst(rst), .tick(tick), .en(en_q), .rate(rate_q),
        .period(period_q), .cnt(cnt_q), .step_pulse(step_pulse)
    );

    pulse_seq #(.S_W(S_W)) u_seq (
        .clk(clk), .rst(rst), .en(en_q), .step_pulse(step_pulse),
        .tone(tone_q), .step(step_q), .level(level)
    );
endmodule

// File: rtl/pulse_chan_chk.sv
module pulse_chan_chk
    import pulse_pkg::*;
#(
    parameter int P_W = PER_W,
    parameter int S_W = STEP_W
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           en,
    input tone_t          tone,
    input rate_t          rate,
    input logic [P_W-1:0] cnt,
    input logic [S_W-1:0] step,
    input logic [3:0]     level
);
    p_silent_off_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> level == 4'd0);

    p_rewind_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> step == '0);

    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en && rate.freeze) |=> $stable(step));

    p_flat_level_r10: assert property (@(posedge clk) disable iff (rst)
        (en && tone.flat) |-> level == tone.vol);

    p_step_on_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && step != $past(step)) |->
            ($past(cnt) == '0 && $past(tick) && step == $past(step) + 1'b1));

    p_no_tick_still_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(step));
endmodule

bind pulse_chan pulse_chan_chk #(.P_W(P_W), .S_W(S_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .en(en_q), .tone(tone_q),
    .rate(rate_q), .cnt(cnt_q), .step(step_q), .level(level)
);

// File: tb/pulse_chan_test.sv
`timescale 1ns/1ps
module pulse_chan_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] level;

    typedef struct {
        logic [3:0] lvl;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    always #2 clk = ~clk;

    pulse_chan uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .level(level)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: level actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [3:0] exp_level(input int k, input int p,
                                             input int d, input int v, input bit flat);
        int s;
        if (flat) return 4'(v);
        s = (k / (p + 1)) % 16;
        return (s >= 15 - d) ? 4'(v) : 4'd0;
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                chk(level, it.lvl, it.req);
            end
        end
    end

    // driver: configure, enable, push expected levels
    task automatic run_pat(input int per, input int eff, input int d, input int v,
                           input bit flat, input bit do_per, input bit do_ctl,
                           input logic [7:0] ctl, input int n, input string req);
        wr(SEL_PHI_C, {1'b0, 3'd0, 4'(per >> 8)});
        if (do_per) wr(2'd1, 8'(per));
        wr(2'd0, {flat, 3'(d), 4'(v)});
        if (do_ctl) wr(2'd3, ctl);
        wr(SEL_PHI_C, {1'b1, 3'd0, 4'(per >> 8)});
        for (int k = 0; k < n; k++) begin
            exp_t it;
            it.lvl = exp_level(k, eff, d, v, flat);
            it.req = req;
            q.push_back(it);
        end
        wait (q.size() == 0);
    endtask

    localparam logic [1:0] SEL_PHI_C = 2'd2;

    initial begin
        #(150000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_up();
    end

    initial begin
        logic [3:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(level, 0, "R11 reset level");

        // R11: rate byte left at its reset value; R2/R9 basic stepping
        run_pat(3, 3, 2, 10, 1'b0, 1'b1, 1'b0, 8'h00, 72, "R2/R9/R11 period 3 duty 2");
        // R1/R4: fine shift 0x123 -> 0x12
        run_pat(12'h123, 12'h12, 5, 7, 1'b0, 1'b1, 1'b1, 8'h02, 19*16+5, "R4 fine shift");
        // R7: clear rate, no period rewrite, full 0x123 pitch
        run_pat(12'h123, 12'h123, 7, 12, 1'b0, 1'b0, 1'b1, 8'h00, 292*9, "R7 pitch restored");
        // R5: coarse overrides fine, 0x2AB -> 0x2
        run_pat(12'h2AB, 2, 0, 15, 1'b0, 1'b1, 1'b1, 8'h06, 96, "R5 coarse shift");
        // R6: upper rate bits ignored
        run_pat(12'h0F7, 12'hF7, 3, 5, 1'b0, 1'b1, 1'b1, 8'hF8, 248*17, "R6 upper bits ignored");
        // R6: freeze wins over shifts, level stays at step 0 (low)
        run_pat(5, 5, 7, 3, 1'b0, 1'b1, 1'b1, 8'h07, 40, "R6 freeze priority");
        // R10: flat mode
        run_pat(1, 1, 0, 6, 1'b1, 1'b1, 1'b1, 8'h00, 30, "R10 flat level");

        // R8: disabling silences flat output
        @(negedge clk); #1;
        chk(level, 6, "R8 before disable");
        wr(SEL_PHI_C, 8'h00);
        #1;
        chk(level, 0, "R8 disabled level");

        // R3: freeze while high holds level; period 0, duty 7, volume 9
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, {1'b0, 3'd7, 4'd9});
        wr(SEL_PHI_C, 8'h80);
        repeat (9) @(negedge clk);
        wr(2'd3, 8'h01);
        #1;
        chk(level, 9, "R3 level high at freeze");
        held = level;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            chk(level, held, "R3 frozen level held");
        end
        wr(2'd3, 8'h00);
        repeat (7) @(negedge clk);
        #1;
        chk(level, 0, "R3 stepping resumed past wrap");

        // R2: tick low holds the waveform
        repeat (6) @(negedge clk);
        tick = 1'b0;
        #1;
        held = level;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            chk(level, held, "R2 no tick no step");
        end
        tick = 1'b1;

        // R8: re-enable rewinds phase; R1 tone rewrite
        run_pat(0, 0, 1, 4, 1'b0, 1'b1, 1'b1, 8'h00, 40, "R8/R1 rewind on re-enable");

        finish_up();
    end
endmodule